// File: doc/BRIEF.md
# Flash Interface Status and Interrupt Unit

This block sits on the register side of a serial flash interface engine. It gathers the engine's condition signals into one status word that software reads over a simple single-cycle register port. Some of these signals are live levels, such as the transmit-empty flag or the controller-on indication. The others are one-cycle event pulses, such as overrun, chip-select rising and instruction end. Each event pulse is held in a sticky flag until software reads the status word.

An interrupt mask selects which status bits may raise the single level-sensitive interrupt line. Software never writes the mask directly. One register sets mask bits, another clears them, and a third reads the mask back. Before it starts a command, software performs a throw-away status read to flush stale events. It then treats the command as finished once it has seen both instruction end and chip-select rising, which may show up in separate reads.

Top module: `flash_irq_status`

## Requirements
- R1: A synchronous active-high reset clears the mask, every event flag, the read data and the interrupt output to zero.
- R2: The status word (offset 0x10) places its bits as follows: bit 0 receive full, bit 1 transmit empty, bit 2 transmitter idle, bit 3 overrun, bit 8 chip-select rise, bit 9 chip-select active, bit 10 instruction end, bit 24 controller on. All other bits read 0. The level bits show the inputs as registered one cycle before the read. Read data appears on the cycle after the read strobe and is 0 when no read is strobed.
- R3: An event pulse (overrun, chip-select rise or instruction end) sets its flag, and the flag stays set until a status read.
- R4: A status read returns the flags and then clears every event flag. The level bits are not affected by the read.
- R5: If an event pulse arrives in the same cycle as a clearing status read, the read returns the old value and the new event stays set for the next read.
- R6: Writing to offset 0x14 sets each mask bit whose write-data bit is 1. Write-data bits that are 0 leave the mask unchanged.
- R7: Writing to offset 0x18 clears each mask bit whose write-data bit is 1. Write-data bits that are 0 leave the mask unchanged.
- R8: The mask reads back at offset 0x1C. Only the eight implemented status positions (value 0x0100070F) can ever be set.
- R9: The interrupt output is a register. It goes high on the cycle after the status word ANDed with the mask is non-zero.
- R10: The instruction-end and chip-select-rise flags are captured independently, so software can collect them across separate status reads.
- R11: A write to any offset other than 0x14 or 0x18 leaves the mask unchanged. A read of offsets 0x14, 0x18 or an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after reg_rd |
| rx_full | input | 1 | Receive data ready level |
| tx_empty | input | 1 | Transmit holding empty level |
| tx_idle | input | 1 | Transmitter idle level |
| cs_active | input | 1 | Chip-select asserted level |
| ctrl_on | input | 1 | Controller enabled level |
| evt_overrun | input | 1 | Overrun event pulse |
| evt_cs_rise | input | 1 | Chip-select rising event pulse |
| evt_instr_end | input | 1 | Instruction end event pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The directed patterns separate level bits from event bits. A lone pulse followed by two reads shows that the flag is sticky and that the read clears it. The same two reads show the level bits surviving the read. A pulse placed exactly on the clearing read shows whether the new event is kept or lost. Mask set and clear writes with mixed ones and zeros, followed by writes to every other offset, tell apart true set or clear behaviour from plain overwrites or stray decoding. A long run of random bus traffic and pulses, compared every cycle against a behavioural model, covers the interrupt latency and how it interacts with read-clear.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int STAT_W = 32;
  localparam int LVL_N  = 5;
  localparam int EVT_N  = 3;

  // level inputs: rx full, tx empty, tx idle, cs active, controller on
  localparam int LVL_POS [LVL_N] = '{0, 1, 2, 9, 24};
  // event inputs: overrun, cs rise, instruction end
  localparam int EVT_POS [EVT_N] = '{3, 8, 10};

  localparam int OFS_STAT = 'h10;
  localparam int OFS_SET  = 'h14;
  localparam int OFS_CLR  = 'h18;
  localparam int OFS_MASK = 'h1C;

  function automatic logic [STAT_W-1:0] impl_bits();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < LVL_N; i++) m[LVL_POS[i]] = 1'b1;
    for (int i = 0; i < EVT_N; i++) m[EVT_POS[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fis_sticky.sv
module fis_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [N-1:0] evt,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flags[g] <= 1'b0;
      else
        flags[g] <= (flags[g] & ~clr) | evt[g];
    end
  end
endmodule

// File: rtl/fis_mask_reg.sv
module fis_mask_reg #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)
      mask <= '0;
    else if (set_en)
      mask <= mask | (wdata & IMPL);
    else if (clr_en)
      mask <= mask & ~wdata;
  end
endmodule

// File: rtl/fis_irq_gen.sv
module fis_irq_gen #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] mask,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & mask);
  end
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import fis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = STAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic              tx_idle,
  input  logic              cs_active,
  input  logic              ctrl_on,
  input  logic              evt_overrun,
  input  logic              evt_cs_rise,
  input  logic              evt_instr_end,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_bits());
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);

  logic [LVL_N-1:0]  lvl_q;
  logic [EVT_N-1:0]  evt_v;
  logic [EVT_N-1:0]  flag_v;
  logic [DATA_W-1:0] evt_w;
  logic [DATA_W-1:0] flag_w;
  logic [DATA_W-1:0] stat_w;
  logic [DATA_W-1:0] mask_q;
  logic              stat_rd;
  logic              set_wr;
  logic              clr_wr;

  // live levels are registered once before use
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= {ctrl_on, cs_active, tx_idle, tx_empty, rx_full};
  end

  assign evt_v   = {evt_instr_end, evt_cs_rise, evt_overrun};
  assign stat_rd = reg_rd && (reg_addr == A_STAT);
  assign set_wr  = reg_wr && (reg_addr == A_SET);
  assign clr_wr  = reg_wr && (reg_addr == A_CLR);

  fis_sticky #(.N(EVT_N)) u_sticky (
    .clk   (clk),
    .rst   (rst),
    .clr   (stat_rd),
    .evt   (evt_v),
    .flags (flag_v)
  );

  // place levels and flags at their status positions
  always_comb begin
    evt_w  = '0;
    flag_w = '0;
    stat_w = '0;
    for (int i = 0; i < EVT_N; i++) begin
      evt_w[EVT_POS[i]]  = evt_v[i];
      flag_w[EVT_POS[i]] = flag_v[i];
    end
    for (int i = 0; i < LVL_N; i++) stat_w[LVL_POS[i]] = lvl_q[i];
    stat_w = stat_w | flag_w;
  end

  fis_mask_reg #(.W(DATA_W), .IMPL(IMPL)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_en (set_wr),
    .clr_en (clr_wr),
    .wdata  (reg_wdata),
    .mask   (mask_q)
  );

  fis_irq_gen #(.W(DATA_W)) u_irq (
    .clk  (clk),
    .rst  (rst),
    .stat (stat_w),
    .mask (mask_q),
    .irq  (irq)
  );

  always_ff @(posedge clk) begin
    if (rst || !reg_rd)
      reg_rdata <= '0;
    else if (reg_addr == A_STAT)
      reg_rdata <= stat_w;
    else if (reg_addr == A_MASK)
      reg_rdata <= mask_q;
    else
      reg_rdata <= '0;
  end
endmodule

// File: rtl/fis_chk.sv
module fis_chk
  import fis_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] evt_w,
  input logic [DATA_W-1:0] flag_w,
  input logic [DATA_W-1:0] stat_w,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_bits());
  logic clr_rd, set_wr, clr_wr;
  assign clr_rd = reg_rd && (reg_addr == ADDR_W'(OFS_STAT));
  assign set_wr = reg_wr && (reg_addr == ADDR_W'(OFS_SET));
  assign clr_wr = reg_wr && (reg_addr == ADDR_W'(OFS_CLR));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && flag_w == '0 && !irq));
  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_rd |=> ((flag_w & $past(flag_w)) == $past(flag_w)));
  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_rd && evt_w == '0) |=> (flag_w == '0));
  // R5
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_w) |=> ((flag_w & $past(evt_w)) == $past(evt_w)));
  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> ((mask_q & $past(reg_wdata & IMPL)) == $past(reg_wdata & IMPL)));
  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((mask_q & $past(reg_wdata)) == '0));
  // R8
  mask_impl_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~IMPL) == '0);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(stat_w & mask_q)));
  // R11
  mask_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(set_wr || clr_wr) |=> $stable(mask_q));
endmodule

bind flash_irq_status fis_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .evt_w     (evt_w),
  .flag_w    (flag_w),
  .stat_w    (stat_w),
  .mask_q    (mask_q),
  .irq       (irq)
);

// File: tb/flash_irq_status_tb.sv
module flash_irq_status_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic rx_full = 0, tx_empty = 0, tx_idle = 0, cs_active = 0, ctrl_on = 0;
  logic evt_overrun = 0, evt_cs_rise = 0, evt_instr_end = 0;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [31:0] m_flags = 0, m_lvl = 0, m_mask = 0, m_rdata = 0;
  bit        m_irq = 0;
  bit [31:0] acc;

  always #(CLK_P/2) clk = ~clk;

  flash_irq_status u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_full(rx_full),
    .tx_empty(tx_empty), .tx_idle(tx_idle), .cs_active(cs_active), .ctrl_on(ctrl_on),
    .evt_overrun(evt_overrun), .evt_cs_rise(evt_cs_rise),
    .evt_instr_end(evt_instr_end), .irq(irq)
  );

  task automatic expect32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: behavioural model step, then compare at the falling edge
  task automatic tick(input string tag);
    bit [31:0] stat, ev, n_rdata, n_flags, n_mask;
    bit n_irq;
    stat = m_flags | m_lvl;
    ev = 0;
    ev[3] = evt_overrun; ev[8] = evt_cs_rise; ev[10] = evt_instr_end;
    n_rdata = 0;
    if (reg_rd && reg_addr == 8'h10) n_rdata = stat;
    if (reg_rd && reg_addr == 8'h1C) n_rdata = m_mask;
    n_flags = ((reg_rd && reg_addr == 8'h10) ? 32'h0 : m_flags) | ev;
    n_mask = m_mask;
    if (reg_wr && reg_addr == 8'h14) n_mask = m_mask | (reg_wdata & 32'h0100_070F);
    if (reg_wr && reg_addr == 8'h18) n_mask = m_mask & ~reg_wdata;
    n_irq = |(stat & m_mask);
    if (rst) begin
      n_rdata = 0; n_flags = 0; n_mask = 0; n_irq = 0;
    end
    @(posedge clk);
    m_rdata = n_rdata; m_flags = n_flags; m_mask = n_mask; m_irq = n_irq;
    m_lvl = 0;
    if (!rst) begin
      m_lvl[0] = rx_full; m_lvl[1] = tx_empty; m_lvl[2] = tx_idle;
      m_lvl[9] = cs_active; m_lvl[24] = ctrl_on;
    end
    @(negedge clk);
    expect32(reg_rdata, m_rdata, {tag, " rdata"});
    expect32({31'b0, irq}, {31'b0, m_irq}, {tag, " irq"});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    reg_addr = a; reg_rd = 1; tick(tag); reg_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    reg_addr = a; reg_wdata = d; reg_wr = 1; tick(tag); reg_wr = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; tick("R1"); tick("R1");
    rst = 0; tick("R1");
    expect32(reg_rdata, 32'h0, "R1 rdata after reset");
    expect32({31'b0, irq}, 32'h0, "R1 irq after reset");
    rd(8'h1C, "R1");
    expect32(reg_rdata, 32'h0, "R1 mask after reset");

    // R2 layout with levels
    rx_full = 1; tx_empty = 1; ctrl_on = 1; tick("R2");
    rd(8'h10, "R2");
    expect32(reg_rdata, 32'h0100_0003, "R2 level layout");
    tx_idle = 1; cs_active = 1; tick("R2");
    rd(8'h10, "R2");
    expect32(reg_rdata, 32'h0100_0207, "R2 all levels");

    // R3 / R4 sticky then cleared, levels kept
    evt_overrun = 1; tick("R3"); evt_overrun = 0;
    tick("R3"); tick("R3");
    rd(8'h10, "R3");
    expect32(reg_rdata, 32'h0100_020F, "R3 overrun sticky");
    rd(8'h10, "R4");
    expect32(reg_rdata, 32'h0100_0207, "R4 event cleared levels kept");

    // R5 collision: event on the clearing read
    reg_addr = 8'h10; reg_rd = 1; evt_instr_end = 1; tick("R5");
    reg_rd = 0; evt_instr_end = 0;
    expect32(reg_rdata, 32'h0100_0207, "R5 read returns old value");
    rd(8'h10, "R5");
    expect32(reg_rdata, 32'h0100_0607, "R5 new event kept");

    // R10 accumulate completion across reads
    acc = 0;
    evt_cs_rise = 1; tick("R10"); evt_cs_rise = 0;
    rd(8'h10, "R10"); acc |= reg_rdata;
    expect32(reg_rdata & 32'h500, 32'h100, "R10 cs rise alone");
    evt_instr_end = 1; tick("R10"); evt_instr_end = 0;
    rd(8'h10, "R10"); acc |= reg_rdata;
    expect32(acc & 32'h500, 32'h500, "R10 both seen");

    // mask set/clear
    wr(8'h14, 32'hFFFF_FFFF, "R8");
    rd(8'h1C, "R8");
    expect32(reg_rdata, 32'h0100_070F, "R8 implemented bits only");
    wr(8'h18, 32'h0000_0007, "R7");
    rd(8'h1C, "R7");
    expect32(reg_rdata, 32'h0100_0708, "R7 partial clear");
    wr(8'h18, 32'hFFFF_FFFF, "R7");
    wr(8'h14, 32'h0000_0400, "R6");
    wr(8'h14, 32'h0000_0100, "R6");
    rd(8'h1C, "R6");
    expect32(reg_rdata, 32'h0000_0500, "R6 set keeps other bits");

    // R9 interrupt timing
    tick("R9");
    evt_instr_end = 1; tick("R9"); evt_instr_end = 0;
    expect32({31'b0, irq}, 32'h0, "R9 irq not yet");
    tick("R9");
    expect32({31'b0, irq}, 32'h1, "R9 irq raised");
    rd(8'h10, "R9");
    expect32({31'b0, irq}, 32'h1, "R9 irq during read");
    tick("R9");
    expect32({31'b0, irq}, 32'h0, "R9 irq dropped after clear");

    // R11 other offsets
    wr(8'h10, 32'hFFFF_FFFF, "R11");
    wr(8'h1C, 32'hFFFF_FFFF, "R11");
    wr(8'h24, 32'hFFFF_FFFF, "R11");
    rd(8'h1C, "R11");
    expect32(reg_rdata, 32'h0000_0500, "R11 mask unchanged");
    rd(8'h24, "R11");
    expect32(reg_rdata, 32'h0, "R11 unmapped read");
    rd(8'h14, "R11");
    expect32(reg_rdata, 32'h0, "R11 set reg reads zero");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 5);
      reg_addr = (sel == 0) ? 8'h10 : (sel == 1) ? 8'h14 : (sel == 2) ? 8'h18 :
                 (sel == 3) ? 8'h1C : (sel == 4) ? 8'h10 : 8'h20;
      reg_rd = ($urandom_range(0, 3) == 0);
      reg_wr = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
      evt_overrun = ($urandom_range(0, 7) == 0);
      evt_cs_rise = ($urandom_range(0, 7) == 0);
      evt_instr_end = ($urandom_range(0, 7) == 0);
      rx_full = $urandom_range(0, 1); tx_empty = $urandom_range(0, 1);
      tx_idle = $urandom_range(0, 1); cs_active = $urandom_range(0, 1);
      ctrl_on = $urandom_range(0, 1);
      tick("R9");
    end
    reg_rd = 0; reg_wr = 0;
    evt_overrun = 0; evt_cs_rise = 0; evt_instr_end = 0;
    tick("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule